// File: doc/BRIEF.md
# Serial Register-Access Bridge

This block is a serial-peripheral slave (clock idle low, data sampled on the rising clock edge, chip select active low) that turns each chip-select frame into one 32-bit register read or write. Accesses to word indices above 1 go out on a simple internal register bus. That bus uses a request/ready handshake whose latency is not fixed. Word 0 (byte offset 0x0) and word 1 (byte offset 0x4) are configuration registers held inside the bridge. Word 0 is the payload-format control. Word 1 holds the read padding count, the too-fast flag and a fixed interface code. These two words never reach the bus.

A frame opens with a 24-bit address field, always sent most-significant byte and bit first. Bit 23 of that field is the write flag. Bits 22:0 are the 32-bit word index, which is the byte address divided by four. A write frame continues with 32 payload bits. A read frame continues with N padding bytes, which are ignored, and then 32 payload bits on MISO. The payload may be sent in either byte order and either bit order, and the host chooses this at run time. The bus read is launched as soon as the last address bit arrives. If its data has not returned when the first payload bit must be driven, the bridge sends zeros and raises the too-fast flag.

The controller is one state machine with these states: S_IDLE (chip select high), S_ADDR (shifting in the address field), S_WDATA (shifting in the write payload), S_PAD (counting padding bits), S_RDATA (driving the read payload) and S_DONE (frame complete, waiting for chip select to rise). Its transitions are as follows. Chip select low moves S_IDLE to S_ADDR. The 24th address bit moves S_ADDR to S_WDATA on a write, to S_PAD on a read with N>0, and to S_RDATA on a read with N=0. The 8N-th padding bit moves S_PAD to S_RDATA. The 32nd payload bit moves S_WDATA or S_RDATA to S_DONE. Chip select rising returns any state to S_IDLE.

Top module: `spibr_top`

## Requirements
- R1: After reset, spi_miso and bus_req are 0. A read of word 1 returns 0x02000000 and a read of word 0 returns 0.
- R2: The address field is 24 bits, most significant bit first, in every payload format. Field bit 23 = 1 marks a write and field bit 23 = 0 marks a read. Field bits 22:0 appear on bus_addr unchanged.
- R3: A complete write frame to a word index above 1 produces exactly one bus write whose bus_wdata is the decoded payload. Once raised, bus_req, bus_we, bus_addr and bus_wdata hold steady until the cycle in which bus_ready is 1.
- R4: A read frame sends 24 address bits, then 8N padding bits (N = word 1 bits 3:0), then 32 data bits on MISO. MISO stays 0 during the address and padding bits. The MOSI value during padding has no effect.
- R5: Word 0 bit 0 selects byte order. 1 sends payload bits 31:24 first; 0 sends bits 7:0 first.
- R6: Word 0 bit 1 selects bit order within each payload byte. 1 sends each byte LSB first; 0 sends it MSB first.
- R7: Writing word 0 with a byte of the form {f0,f1,0000,f1,f0}, repeated in all four bytes, sets the format to {f1,f0} whatever the current format is.
- R8: Word 1 reads as bits 31:24 = 0x02, bit 16 = too-fast flag, bits 3:0 = N, and 0 elsewhere. Word 0 reads as bits 1:0 = format, and 0 elsewhere.
- R9: If a bus read has not returned by the first payload bit, the payload sent is all zeros and word 1 bit 16 becomes 1. A ready that arrives in that same cycle counts as in time.
- R10: Any complete write to word 1 clears bit 16.
- R11: A frame cut short by chip select rising causes no bus write and leaves both configuration words unchanged.
- R12: Asserting rst_n low returns the format to 0 and N to 0, and clears the too-fast flag.
- R13: Reads and writes of word indices 0 and 1 never raise bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; serial inputs are oversampled in this domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| bus_req | output | 1 | Register bus request, held until bus_ready |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | 23 | 32-bit word index of the access |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid while bus_ready is 1 |
| bus_ready | input | 1 | Access complete, one cycle |

## Verification
The bus read return (bus_ready) and the load of the first payload bit onto MISO can happen in the same clock cycle, and that cycle decides between real data and a too-fast error. The bench makes this happen by running padding-free reads with the bus latency swept one cycle at a time across the window around the first payload edge. Each outcome is judged for consistency: either the model's value arrives and word 1 bit 16 stays clear, or zeros arrive and bit 16 is set. The shortest latency must give data and the longest must give the error.

// File: rtl/spb_pkg.sv
package spb_pkg;
    localparam int AFIELD_W = 24;
    localparam int DATA_W   = 32;
    localparam int NBYTES   = DATA_W / 8;
    localparam int WIDX_W   = AFIELD_W - 1;
    localparam int PAD_W    = 4;
    localparam int CNT_W    = $clog2(8 * (2 ** PAD_W) + DATA_W);
    localparam logic [7:0] IFACE_ID = 8'h02;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_WDATA, S_PAD, S_RDATA, S_DONE
    } state_t;

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    // serial stream held with the first bit sent in bit DATA_W-1
    function automatic logic [DATA_W-1:0] wire_to_word(input logic [DATA_W-1:0] w,
                                                       input logic [1:0] f);
        logic [DATA_W-1:0] v;
        logic [7:0] b;
        v = '0;
        for (int k = 0; k < NBYTES; k++) begin
            b = w[DATA_W-8-8*k +: 8];
            if (f[1]) b = rev8(b);
            if (f[0]) v[8*(NBYTES-1-k) +: 8] = b;
            else      v[8*k +: 8] = b;
        end
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] word_to_wire(input logic [DATA_W-1:0] v,
                                                       input logic [1:0] f);
        logic [DATA_W-1:0] w;
        logic [7:0] b;
        w = '0;
        for (int k = 0; k < NBYTES; k++) begin
            b = f[0] ? v[8*(NBYTES-1-k) +: 8] : v[8*k +: 8];
            if (f[1]) b = rev8(b);
            w[DATA_W-8-8*k +: 8] = b;
        end
        return w;
    endfunction
endpackage

// File: rtl/spb_sync.sv
module spb_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] chain [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
        end
    end

    assign q      = chain[STAGES-1];
    assign q_prev = chain[STAGES];
endmodule

// File: rtl/spb_cfg.sv
module spb_cfg
    import spb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_set,
    output logic [1:0]        fmt,
    output logic [PAD_W-1:0]  pad,
    output logic              stat,
    output logic [DATA_W-1:0] rd_ctrl,
    output logic [DATA_W-1:0] rd_cfg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt  <= 2'b00;
            pad  <= '0;
            stat <= 1'b0;
        end else begin
            if (wr_en && !wr_sel) fmt <= wr_data[1:0];
            if (wr_en && wr_sel) begin
                pad  <= wr_data[PAD_W-1:0];
                stat <= 1'b0;
            end else if (stat_set) begin
                stat <= 1'b1;
            end
        end
    end

    assign rd_ctrl = {{(DATA_W-2){1'b0}}, fmt};
    assign rd_cfg  = {IFACE_ID, 7'd0, stat, {(16-PAD_W){1'b0}}, pad};

    // R10: a config/status write clears the flag
    p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> !stat);
    // R9: a late read sets the flag
    p_stat_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_set && !wr_en) |=> stat);
endmodule

// File: rtl/spibr_top.sv
module spibr_top
    import spb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              bus_req,
    output logic              bus_we,
    output logic [WIDX_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);
    logic [2:0] s_q, s_p;
    spb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({spi_cs_n, spi_sclk, spi_mosi}),
        .q(s_q), .q_prev(s_p));

    wire cs_lo    = ~s_q[2];
    wire sck_rise = s_q[1] & ~s_p[1];
    wire sck_fall = ~s_q[1] & s_p[1];
    wire mosi_s   = s_q[0];
    wire bit_in   = cs_lo & sck_rise;

    state_t state, nstate;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sr, tx, rd_buf;
    logic [WIDX_W-1:0] addr_q;
    logic              rd_have, first;

    logic [1:0]        fmt;
    logic [PAD_W-1:0]  pad;
    logic              stat, cfg_wr, stat_set;
    logic [DATA_W-1:0] rd_ctrl, rd_cfg, rx_word;

    wire [CNT_W-1:0]  pad_bits = CNT_W'({pad, 3'b000});
    wire [WIDX_W-1:0] widx     = {sr[WIDX_W-2:0], mosi_s};
    wire addr_done = (state == S_ADDR)  && bit_in && (cnt == CNT_W'(AFIELD_W-1));
    wire wdat_done = (state == S_WDATA) && bit_in && (cnt == CNT_W'(DATA_W-1));
    wire pad_done  = (state == S_PAD)   && bit_in && (cnt == pad_bits - 1'b1);
    wire rdat_done = (state == S_RDATA) && bit_in && (cnt == CNT_W'(DATA_W-1));
    wire rd_ret    = bus_req && !bus_we && bus_ready;
    wire avail     = rd_have || rd_ret;
    wire load_now  = (state == S_RDATA) && cs_lo && sck_fall && first;

    assign rx_word  = wire_to_word({sr[DATA_W-2:0], mosi_s}, fmt);
    assign cfg_wr   = wdat_done && (addr_q < WIDX_W'(2));
    assign stat_set = load_now && !avail;

    spb_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_sel(addr_q[0]),
        .wr_data(rx_word), .stat_set(stat_set), .fmt(fmt), .pad(pad),
        .stat(stat), .rd_ctrl(rd_ctrl), .rd_cfg(rd_cfg));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next-state decode
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:  if (cs_lo) nstate = S_ADDR;
            S_ADDR:  if (addr_done)
                         nstate = sr[WIDX_W-1] ? S_WDATA
                                : (pad == '0) ? S_RDATA : S_PAD;
            S_WDATA: if (wdat_done) nstate = S_DONE;
            S_PAD:   if (pad_done)  nstate = S_RDATA;
            S_RDATA: if (rdat_done) nstate = S_DONE;
            S_DONE:  nstate = S_DONE;
            default: nstate = S_IDLE;
        endcase
        if (!cs_lo) nstate = S_IDLE;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; sr <= '0; tx <= '0; rd_buf <= '0; addr_q <= '0;
            rd_have <= 1'b0; first <= 1'b0; spi_miso <= 1'b0;
            bus_req <= 1'b0; bus_we <= 1'b0; bus_addr <= '0; bus_wdata <= '0;
        end else begin
            if (state != nstate) cnt <= '0;
            else if (bit_in)     cnt <= cnt + 1'b1;
            if (bit_in) sr <= {sr[DATA_W-2:0], mosi_s};

            if (bus_req && bus_ready) begin
                bus_req <= 1'b0;
                if (!bus_we) begin
                    rd_buf  <= bus_rdata;
                    rd_have <= 1'b1;
                end
            end

            if (addr_done) begin
                addr_q <= widx;
                if (!sr[WIDX_W-1]) begin
                    if (widx < WIDX_W'(2)) begin
                        rd_buf  <= widx[0] ? rd_cfg : rd_ctrl;
                        rd_have <= 1'b1;
                    end else if (!bus_req) begin
                        bus_req  <= 1'b1;
                        bus_we   <= 1'b0;
                        bus_addr <= widx;
                        rd_have  <= 1'b0;
                    end
                end
            end

            if (wdat_done && !cfg_wr && !bus_req) begin
                bus_req   <= 1'b1;
                bus_we    <= 1'b1;
                bus_addr  <= addr_q;
                bus_wdata <= rx_word;
            end

            if (state != S_RDATA && nstate == S_RDATA) first <= 1'b1;

            if (state != S_RDATA) begin
                spi_miso <= 1'b0;
            end else if (cs_lo && sck_fall) begin
                if (first) begin
                    tx <= word_to_wire(avail ? (rd_have ? rd_buf : bus_rdata) : '0, fmt)
                          << 1;
                    spi_miso <= word_to_wire(avail ? (rd_have ? rd_buf : bus_rdata) : '0,
                                             fmt)[DATA_W-1];
                    first <= 1'b0;
                end else begin
                    spi_miso <= tx[DATA_W-1];
                    tx <= tx << 1;
                end
            end
        end
    end

    // R4: MISO idle during address and padding
    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR || state == S_PAD) |-> !spi_miso);
    // R3: request fields held until ready
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr)
                                     && $stable(bus_we) && $stable(bus_wdata)));
    // R13: internal words never reach the bus
    p_noint_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr > WIDX_W'(1)));
    // R11: a write cut short launches nothing
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WDATA && !cs_lo) |=> !$rose(bus_req));
    // R1: no output activity while chip select is high
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> !spi_miso);
endmodule

// File: tb/sim_spibr_top.sv
module sim_spibr_top;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;

    logic clk = 0, rst_n = 0;
    logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0;
    logic spi_miso, bus_req, bus_we, bus_ready = 0;
    logic [22:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata = '0;

    spibr_top u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, lat = 2, lat_cnt = 0;
    int wr_cnt = 0, req_cnt = 0;
    logic [22:0] last_waddr;
    logic [31:0] last_wdata;
    logic [1:0] cur_fmt = 0;
    int cur_pad = 0;
    bit done = 0;

    function automatic logic [31:0] model_val(input logic [22:0] a);
        return {8'h5A, 1'b0, a} ^ 32'h0013_C700;
    endfunction

    // bus target model
    always @(posedge clk) begin
        if (bus_req && !bus_ready) begin
            if (lat_cnt == 0) req_cnt <= req_cnt + 1;
            if (lat_cnt >= lat) begin
                bus_ready <= 1;
                bus_rdata <= model_val(bus_addr);
                if (bus_we) begin
                    wr_cnt <= wr_cnt + 1;
                    last_waddr <= bus_addr;
                    last_wdata <= bus_wdata;
                end
            end else lat_cnt <= lat_cnt + 1;
        end else begin
            bus_ready <= 0;
            lat_cnt <= 0;
        end
    end

    function automatic logic [31:0] enc(input logic [31:0] v, input logic [1:0] f);
        logic [31:0] w;
        for (int p = 0; p < 32; p++) begin
            int sb = f[0] ? 3 - p/8 : p/8;
            int bb = f[1] ? p%8 : 7 - p%8;
            w[31-p] = v[8*sb+bb];
        end
        return w;
    endfunction

    function automatic logic [31:0] dec(input logic [31:0] w, input logic [1:0] f);
        logic [31:0] v;
        for (int p = 0; p < 32; p++) begin
            int sb = f[0] ? 3 - p/8 : p/8;
            int bb = f[1] ? p%8 : 7 - p%8;
            v[8*sb+bb] = w[31-p];
        end
        return v;
    endfunction

    function automatic logic [31:0] pat(input logic [1:0] f);
        return {4{f[0], f[1], 4'b0000, f[1], f[0]}};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic frame(input logic [23:0] af, input logic [31:0] wout, input int nbits,
                         input int abort_at, output logic [31:0] rx, output bit quiet);
        bit rd = !af[23];
        rx = '0;
        quiet = 1;
        @(negedge clk); spi_cs_n = 0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i == abort_at) break;
            if (i < 24)   spi_mosi = af[23-i];
            else if (!rd) spi_mosi = wout[31-(i-24)];
            else          spi_mosi = (i < nbits - 32);   // padding sent as ones
            repeat (HALF) @(negedge clk);
            if (rd) begin
                if (i >= nbits - 32) rx = {rx[30:0], spi_miso};
                else if (spi_miso) quiet = 0;
            end
            spi_sclk = 1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1; spi_mosi = 0;
        repeat (3*HALF) @(negedge clk);
    endtask

    task automatic reg_write(input logic [24:0] baddr, input logic [31:0] v, input int abort_at);
        logic [31:0] rx; bit q;
        frame({1'b1, baddr[24:2]}, enc(v, cur_fmt), 56, abort_at, rx, q);
    endtask

    task automatic reg_read(input logic [24:0] baddr, output logic [31:0] v, output bit quiet);
        logic [31:0] rx;
        frame({1'b0, baddr[24:2]}, '0, 56 + 8*cur_pad, -1, rx, quiet);
        v = dec(rx, cur_fmt);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        cur_fmt = 0; cur_pad = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v; bit q;
        chk("R1 miso after reset", {31'd0, spi_miso}, 0);
        chk("R1 bus_req after reset", {31'd0, bus_req}, 0);
        reg_read(25'h4, v, q);
        chk("R1 R8 cfgstat default", v, 32'h0200_0000);
        reg_read(25'h0, v, q);
        chk("R1 ctrl default", v, 0);
    endtask

    task automatic t_basic();
        logic [31:0] v; bit q;
        int w0 = wr_cnt;
        reg_write(25'h100, 32'h1234_5678, -1);
        repeat (20) @(negedge clk);
        chk("R3 one bus write", wr_cnt - w0, 1);
        chk("R2 write word index", {9'd0, last_waddr}, 32'h40);
        chk("R3 write data", last_wdata, 32'h1234_5678);
        reg_read(25'h200, v, q);
        chk("R4 read data N=0", v, model_val(23'h80));
        chk("R4 miso quiet in address", {31'd0, q}, 1);
    endtask

    task automatic t_formats();
        logic [31:0] v; bit q;
        for (int f = 1; f <= 4; f++) begin
            logic [1:0] nf = 2'(f);
            int r0 = req_cnt;
            reg_write(25'h0, pat(nf), -1);   // written under previous format
            cur_fmt = nf;
            reg_read(25'h0, v, q);
            chk($sformatf("R7 R8 ctrl readback fmt%0d", nf), v, {30'd0, nf});
            repeat (20) @(negedge clk);
            chk("R13 ctrl access stays off bus", req_cnt - r0, 0);
            reg_write(25'h1A4, 32'hA1B2_C3D4 ^ f, -1);
            repeat (20) @(negedge clk);
            chk($sformatf("R5 R6 write decode fmt%0d", nf), last_wdata, 32'hA1B2_C3D4 ^ f);
            reg_read(25'h3F8, v, q);
            chk($sformatf("R5 R6 read encode fmt%0d", nf), v, model_val(23'hFE));
        end
    endtask

    task automatic t_pad();
        logic [31:0] v; bit q;
        reg_write(25'h4, 32'd2, -1);
        cur_pad = 2;
        lat = 100;
        reg_read(25'h444, v, q);
        chk("R4 read data N=2 slow bus", v, model_val(23'h111));
        chk("R4 miso quiet in padding", {31'd0, q}, 1);
        reg_read(25'h4, v, q);
        chk("R8 cfgstat pad=2 no flag", v, 32'h0200_0002);
        lat = 2;
    endtask

    task automatic t_too_fast();
        logic [31:0] v; bit q;
        reg_write(25'h4, 32'd0, -1);
        cur_pad = 0;
        lat = 150;
        reg_read(25'h500, v, q);
        chk("R9 late read returns zeros", v, 0);
        reg_read(25'h4, v, q);
        chk("R9 flag set", v, 32'h0201_0000);
        lat = 2;
        reg_write(25'h4, 32'd0, -1);
        reg_read(25'h4, v, q);
        chk("R10 flag cleared by write", v, 32'h0200_0000);
    endtask

    task automatic t_abort();
        logic [31:0] v; bit q;
        int w0 = wr_cnt;
        reg_write(25'h300, 32'hDEAD_BEEF, 40);
        repeat (40) @(negedge clk);
        chk("R11 aborted write gives no bus write", wr_cnt - w0, 0);
        reg_write(25'h4, 32'd7, 50);
        reg_read(25'h4, v, q);
        chk("R11 aborted cfg write ignored", v, 32'h0200_0000);
        reg_write(25'h300, 32'h0BAD_F00D, -1);
        repeat (20) @(negedge clk);
        chk("R11 next frame after abort works", last_wdata, 32'h0BAD_F00D);
    endtask

    task automatic t_rst();
        logic [31:0] v; bit q;
        reg_write(25'h0, pat(2'b11), -1);
        cur_fmt = 2'b11;
        reg_write(25'h4, 32'd5, -1);
        do_reset();
        reg_read(25'h0, v, q);
        chk("R12 ctrl after reset", v, 0);
        reg_read(25'h4, v, q);
        chk("R12 cfgstat after reset", v, 32'h0200_0000);
    endtask

    task automatic t_sweep();
        logic [31:0] v, s; bit q;
        for (int l = 0; l <= 12; l++) begin
            lat = l;
            reg_read(25'h600, v, q);
            reg_read(25'h4, s, q);
            n_chk++;
            if (!((v == model_val(23'h180) && s == 32'h0200_0000) ||
                  (v == 0 && s == 32'h0201_0000))) begin
                n_fail++;
                $display("FAIL R9 sweep lat=%0d actual=%h/%h expected data or zero+flag",
                         l, v, s);
            end
            if (l == 0)  chk("R9 zero latency is in time", s, 32'h0200_0000);
            if (l == 12) chk("R9 long latency flags", s, 32'h0201_0000);
            if (s[16]) reg_write(25'h4, 32'd0, -1);
        end
        lat = 2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_formats();
        t_pad();
        t_too_fast();
        t_abort();
        t_rst();
        t_sweep();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule